// File: doc/BRIEF.md
# Asynchronous Expansion Bus Controller

This block turns single requests from an internal port into accesses on an external 16-bit asynchronous peripheral bus. The bus has eight chip selects and a 24-bit address. Every access steps through five phases in a fixed order: address, setup, strobe, hold and recovery. Each chip select has its own configuration word. That word sets the length of every phase in clocks of the interface clock, picks the strobe style and picks whether address and data share pins. It also sets the size of the chip select's address window and whether the chip select is enabled. Only one access is handled at a time. The port reports the end of an access with a one-cycle done pulse. It raises an error flag when the address falls outside the selected window.

When reset is released, the block also captures the levels on the strap inputs. These inputs share the 24 address pins. The captured value is held for configuration software to read. Output pins that a real pad would tristate are modelled here as a value plus an output enable.

Top module: `exp_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, all chip selects are high (inactive). The read, write and data strobes (`ext_rd_n`, `ext_wr_n`, `ext_ds_n`) are high, `ext_rnw` is high, `ext_ale` and `ext_doe` are low, `busy`, `req_done` and `req_err` are low, and every configuration word reads 0.
- R2: Writing a configuration word stores it for the chip select given by `cfg_sel`, and `cfg_rdata` returns that word. The field layout is as follows. Bits [3:0] hold the address phase, [7:4] the setup phase, [11:8] the strobe phase, [15:12] the hold phase and [19:16] the recovery phase. Bit 20 selects multiplexed mode, bit 21 selects the strobe style (0 = separate read and write strobes, 1 = direction plus data strobe), bits [25:22] hold the window size code, and bit 31 enables the chip select.
- R3: A phase field value f lasts f+1 clocks. For an accepted in-window access, `req_done` is a one-cycle pulse. It is first high after A+S+T+H+R+5 rising edges have followed the accepting edge.
- R4: With style 0, the strobe phase drives `ext_rd_n` (read) or `ext_wr_n` (write) low for T+1 clocks, while `ext_ds_n` and `ext_rnw` stay high. With style 1, `ext_ds_n` is low for T+1 clocks and `ext_rd_n`/`ext_wr_n` stay high. In that style `ext_rnw` is low while the chip select is active on a write and stays high on a read.
- R5: In multiplexed mode, `ext_ale` is high for the A+1 clocks of the address phase. During those clocks `ext_doe` is high and `ext_dout` carries address bits [15:0]. In separate mode `ext_ale` stays low.
- R6: A write drives `req_wdata` on `ext_dout` with `ext_doe` high through setup, strobe and hold (S+T+H+3 clocks). A read never raises `ext_doe` outside a multiplexed address phase.
- R7: A read returns, on `req_rdata` while `req_done` is high, the value `ext_din` had on the last clock of the strobe phase.
- R8: A request is refused when its chip select is disabled, or when its address is not below 512 << size code. A refused request gives `req_done` and `req_err` in the cycle after acceptance, and no external pin moves.
- R9: A request presented while `busy` is high is ignored: no chip select other than the active one goes low, and no extra done pulse follows.
- R10: An access uses the configuration as it stood before its accepting edge. A write to that word at the same edge or later in the access does not change its timing.
- R11: `strap_q` takes the value of `strap_in` at the first rising edge after reset release, and stays constant afterwards.
- R12: At most one chip select is low at any time. Only the addressed one goes low, for the A+S+T+H+4 clocks from address to hold.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Chip select whose configuration is written or read |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word of `cfg_sel` |
| strap_in | input | 24 | Strap levels on the address pins |
| strap_q | output | 24 | Strap value captured after reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip select |
| req_addr | input | 24 | Byte address inside the window |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request refused (with `req_done`) |
| req_rdata | output | 16 | Read data |
| ext_cs_n | output | 8 | Active-low chip selects |
| ext_addr | output | 24 | External address |
| ext_ale | output | 1 | Address latch pulse (multiplexed mode) |
| ext_rd_n | output | 1 | Read strobe (style 0) |
| ext_wr_n | output | 1 | Write strobe (style 0) |
| ext_rnw | output | 1 | Direction, high = read (style 1) |
| ext_ds_n | output | 1 | Data strobe (style 1) |
| ext_dout | output | 16 | Address/data driven out |
| ext_doe | output | 1 | Output enable for `ext_dout` |
| ext_din | input | 16 | Data from the bus |

## Verification
Two events can land on the same clock edge. A configuration write can arrive at the edge that accepts a request, and a new request can be presented during the cycle that carries the previous access's done pulse. The bench forces the first case by raising `cfg_we` and `req_valid` together. It then judges the result by the strobe, chip-select and done timing, which must follow the old word. It forces the second case by issuing the next request in the done cycle. That request must be accepted at once, and its done pulse must arrive exactly one full access length later. Mid-access configuration writes and requests are also injected, and must leave the running access unchanged.

// File: rtl/exp_bus_ctrl.sv
module exp_bus_ctrl #(
  parameter int NCS       = 8,
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int CW        = 32,
  parameter int PW        = 4,
  parameter int MIN_WIN_LG = 9,
  localparam int CSW      = $clog2(NCS),
  localparam int MUX_BIT  = 5 * PW,
  localparam int STY_BIT  = 5 * PW + 1,
  localparam int SZ_LO    = 5 * PW + 2,
  localparam int EN_BIT   = CW - 1,
  localparam int CUR_W    = 5 * PW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CSW-1:0] cfg_sel,
  input  logic [CW-1:0]  cfg_wdata,
  output logic [CW-1:0]  cfg_rdata,
  input  logic [AW-1:0]  strap_in,
  output logic [AW-1:0]  strap_q,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           busy,
  output logic           req_done,
  output logic           req_err,
  output logic [DW-1:0]  req_rdata,
  output logic [NCS-1:0] ext_cs_n,
  output logic [AW-1:0]  ext_addr,
  output logic           ext_ale,
  output logic           ext_rd_n,
  output logic           ext_wr_n,
  output logic           ext_rnw,
  output logic           ext_ds_n,
  output logic [DW-1:0]  ext_dout,
  output logic           ext_doe,
  input  logic [DW-1:0]  ext_din
);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SETUP, PH_STRB, PH_HOLD, PH_RECV
  } phase_e;

  phase_e          ph_q;
  logic [PW-1:0]   cnt_q;
  logic [CW-1:0]   cfg_q [NCS];
  logic [CUR_W-1:0] cur_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wd_q;
  logic [CSW-1:0]  cs_q;
  logic            wr_q;
  logic            strap_seen;

  function automatic logic [PW-1:0] ph_len(input logic [CUR_W-1:0] c, input int idx);
    return c[idx*PW +: PW];
  endfunction

  logic [CW-1:0] sel_cfg;
  logic [AW:0]   win_lim;
  logic          hit;

  assign sel_cfg   = cfg_q[req_cs];
  assign win_lim   = (AW+1)'(1) << (MIN_WIN_LG + int'(sel_cfg[SZ_LO +: 4]));
  assign hit       = sel_cfg[EN_BIT] && ({1'b0, req_addr} < win_lim);
  assign cfg_rdata = cfg_q[cfg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCS; i++) cfg_q[i] <= '0;
    end else if (cfg_we) begin
      cfg_q[cfg_sel] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_seen <= 1'b0;
    end else if (!strap_seen) begin
      strap_q    <= strap_in;
      strap_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      cur_q     <= '0;
      addr_q    <= '0;
      wd_q      <= '0;
      cs_q      <= '0;
      wr_q      <= 1'b0;
      req_done  <= 1'b0;
      req_err   <= 1'b0;
      req_rdata <= '0;
    end else begin
      req_done <= 1'b0;
      req_err  <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (req_valid) begin
          if (!hit) begin
            req_done <= 1'b1;
            req_err  <= 1'b1;
          end else begin
            cur_q  <= sel_cfg[CUR_W-1:0];
            addr_q <= req_addr;
            wd_q   <= req_wdata;
            cs_q   <= req_cs;
            wr_q   <= req_write;
            cnt_q  <= ph_len(sel_cfg[CUR_W-1:0], 0);
            ph_q   <= PH_ADDR;
          end
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        unique case (ph_q)
          PH_ADDR:  begin ph_q <= PH_SETUP; cnt_q <= ph_len(cur_q, 1); end
          PH_SETUP: begin ph_q <= PH_STRB;  cnt_q <= ph_len(cur_q, 2); end
          PH_STRB:  begin
            ph_q  <= PH_HOLD;
            cnt_q <= ph_len(cur_q, 3);
            if (!wr_q) req_rdata <= ext_din;
          end
          PH_HOLD:  begin ph_q <= PH_RECV;  cnt_q <= ph_len(cur_q, 4); end
          default:  begin ph_q <= PH_IDLE;  req_done <= 1'b1; end
        endcase
      end
    end
  end

  logic active, cs_on, strb, mux, sty, dwin;

  assign active = ph_q != PH_IDLE;
  assign cs_on  = active && ph_q != PH_RECV;
  assign strb   = ph_q == PH_STRB;
  assign mux    = cur_q[MUX_BIT];
  assign sty    = cur_q[STY_BIT];
  assign dwin   = ph_q == PH_SETUP || ph_q == PH_STRB || ph_q == PH_HOLD;
  assign busy   = active;

  assign ext_cs_n = cs_on ? ~(NCS'(1) << cs_q) : '1;
  assign ext_addr = active ? addr_q : '0;
  assign ext_ale  = ph_q == PH_ADDR && mux;
  assign ext_rd_n = !(strb && !sty && !wr_q);
  assign ext_wr_n = !(strb && !sty && wr_q);
  assign ext_ds_n = !(strb && sty);
  assign ext_rnw  = !(cs_on && sty && wr_q);
  assign ext_doe  = ext_ale || (dwin && wr_q);
  assign ext_dout = ext_ale ? addr_q[DW-1:0] : ((dwin && wr_q) ? wd_q : '0);

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n)); // R12
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (&ext_cs_n && !ext_ale && !ext_doe)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R3
  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ds_n |-> (ext_rd_n && ext_wr_n)); // R4
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n)); // R4
  AST_ALE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |-> (ext_doe && !(&ext_cs_n))); // R5
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_seen && $past(strap_seen)) |-> $stable(strap_q)); // R11
  AST_BUSY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ext_addr) && $stable(ext_rnw || !ext_cs_n[cs_q]))); // R9

endmodule

// File: tb/exp_bus_ctrl_bench.sv
module exp_bus_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [23:0] strap_in = 24'hA50F3C;
  logic [23:0] strap_q;
  logic        req_valid = 0, req_write = 0;
  logic [2:0]  req_cs = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        busy, req_done, req_err;
  logic [15:0] req_rdata;
  logic [7:0]  ext_cs_n;
  logic [23:0] ext_addr;
  logic        ext_ale, ext_rd_n, ext_wr_n, ext_rnw, ext_ds_n, ext_doe;
  logic [15:0] ext_dout, ext_din;
  logic [7:0]  low_ctr = 0;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  exp_bus_ctrl u_exp_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .strap_in(strap_in),
    .strap_q(strap_q), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .req_done(req_done), .req_err(req_err),
    .req_rdata(req_rdata), .ext_cs_n(ext_cs_n), .ext_addr(ext_addr),
    .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_rnw(ext_rnw), .ext_ds_n(ext_ds_n), .ext_dout(ext_dout),
    .ext_doe(ext_doe), .ext_din(ext_din)
  );

  // device model: read value encodes the strobe clock count seen so far
  always @(negedge clk) begin
    if (!ext_rd_n || !ext_ds_n) low_ctr <= low_ctr + 8'd1;
    else low_ctr <= 8'd0;
  end
  assign ext_din = ext_addr[15:0] ^ {8'h00, low_ctr};

  task automatic chk(input string req, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int a, s, t, h, r, input bit mx, sy,
                                        input int sz, input bit en);
    return {en, 5'b0, 4'(sz), sy, mx, 4'(r), 4'(h), 4'(t), 4'(s), 4'(a)};
  endfunction

  function automatic bit in_win(input logic [31:0] c, input logic [23:0] ad);
    return c[31] && ({1'b0, ad} < (25'd1 << (9 + int'(c[25:22]))));
  endfunction

  function automatic int lat_of(input logic [31:0] c);
    return int'(c[3:0]) + int'(c[7:4]) + int'(c[11:8]) + int'(c[15:12]) + int'(c[19:16]) + 6;
  endfunction

  task automatic write_cfg(input logic [2:0] cs, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = cs; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // inj: 0 none, 1 foreign request mid-access, 2 config write mid-access, 3 config write at accept
  task automatic access(input logic [2:0] cs, input bit wr, input logic [23:0] ad,
                        input logic [15:0] wd, input logic [31:0] c, input int inj,
                        input bit now);
    int n, m_cs, m_oth, m_ale, m_badmux, m_rd, m_wr, m_ds, m_rnw, m_doe, m_badwd, extra;
    bit hit, err;
    logic [15:0] rd;
    int a, s, t, h;
    n = 0; m_cs = 0; m_oth = 0; m_ale = 0; m_badmux = 0; m_rd = 0; m_wr = 0;
    m_ds = 0; m_rnw = 0; m_doe = 0; m_badwd = 0; extra = 0; err = 0; rd = 0;
    a = int'(c[3:0]); s = int'(c[7:4]); t = int'(c[11:8]); h = int'(c[15:12]);
    hit = in_win(c, ad);
    if (!now) @(negedge clk);
    req_valid = 1; req_write = wr; req_cs = cs; req_addr = ad; req_wdata = wd;
    if (inj == 3) begin cfg_we = 1; cfg_sel = cs; cfg_wdata = mk_cfg(15,15,15,15,15,~c[20],~c[21],15,1); end
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    n = 1;
    forever begin
      if (inj == 1 && n == 3) begin
        req_valid = 1; req_cs = cs + 3'd1; req_addr = 24'h0; req_write = 0;
      end else if (inj == 1 && n == 4) req_valid = 0;
      if (inj == 2 && n == 2) begin
        cfg_we = 1; cfg_sel = cs; cfg_wdata = mk_cfg(15,15,15,15,15,~c[20],~c[21],15,1);
      end else if (inj == 2 && n == 3) cfg_we = 0;
      if (!ext_cs_n[cs]) m_cs++;
      if ((~ext_cs_n & ~(8'd1 << cs)) != 8'd0) m_oth++;
      if (ext_ale) begin m_ale++; if (!ext_doe || ext_dout != ad[15:0]) m_badmux++; end
      if (!ext_rd_n) m_rd++;
      if (!ext_wr_n) m_wr++;
      if (!ext_ds_n) m_ds++;
      if (!ext_rnw) m_rnw++;
      if (ext_doe && !ext_ale) begin m_doe++; if (ext_dout != wd) m_badwd++; end
      if (req_done) begin err = req_err; rd = req_rdata; break; end
      if (n > 400) begin chk("watchdog", n, 0); break; end
      @(negedge clk); n++;
    end
    if (!now || inj != 0) begin
      repeat (8) begin @(negedge clk); if (req_done) extra++; end
    end
    if (!hit) begin
      chk("R8 err latency", n, 1);
      chk("R8 err flag", err, 1);
      chk("R8 no pins", m_cs + m_oth + m_ale + m_rd + m_wr + m_ds + m_rnw + m_doe, 0);
      return;
    end
    chk("R3 done timing", n, lat_of(c));
    chk("R3 no err", err, 0);
    chk("R12 cs length", m_cs, a + s + t + h + 4);
    chk("R12 R9 other cs", m_oth, 0);
    chk("R9 no extra done", extra, 0);
    chk("R5 ale clocks", m_ale, c[20] ? a + 1 : 0);
    chk("R5 ale addr", m_badmux, 0);
    chk("R4 rd strobe", m_rd, (!c[21] && !wr) ? t + 1 : 0);
    chk("R4 wr strobe", m_wr, (!c[21] && wr) ? t + 1 : 0);
    chk("R4 ds strobe", m_ds, c[21] ? t + 1 : 0);
    chk("R4 rnw", m_rnw, (c[21] && wr) ? a + s + t + h + 4 : 0);
    chk("R6 doe clocks", m_doe, wr ? s + t + h + 3 : 0);
    chk("R6 write data", m_badwd, 0);
    if (!wr) chk("R7 read data", rd, ad[15:0] ^ {8'h00, 8'(t + 1)});
  endtask

  initial begin
    logic [31:0] c, c2;
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 cs_n", ext_cs_n, 8'hFF);
    chk("R1 strobes", {ext_rd_n, ext_wr_n, ext_ds_n, ext_rnw}, 4'hF);
    chk("R1 ale/doe", {ext_ale, ext_doe}, 0);
    chk("R1 busy/done/err", {busy, req_done, req_err}, 0);
    chk("R1 strap", strap_q, 0);
    rst_n = 1;
    @(negedge clk);
    strap_in = 24'h123456;
    repeat (2) @(negedge clk);
    chk("R11 strap capture", strap_q, 24'hA50F3C);
    cfg_sel = 3'd5;
    #1 chk("R1 cfg reads zero", cfg_rdata, 0);

    // R2 write/read back
    c = mk_cfg(1, 2, 3, 0, 1, 1, 0, 3, 1);
    write_cfg(3'd5, c);
    cfg_sel = 3'd5;
    #1 chk("R2 readback", cfg_rdata, c);

    // directed: muxed separate-strobe read and write
    access(3'd5, 0, 24'h0ABC, 16'h0, c, 0, 0);
    access(3'd5, 1, 24'h0FFE, 16'hBEEF, c, 0, 0);
    // R8 window edge: 512<<3 = 4096 is outside, 4095 inside
    access(3'd5, 0, 24'h0FFF, 16'h0, c, 0, 0);
    access(3'd5, 0, 24'h1000, 16'h0, c, 0, 0);
    // R8 disabled chip select
    access(3'd2, 0, 24'h0, 16'h0, 32'h0, 0, 0);
    // style 1, separate address/data, all phases minimal
    c = mk_cfg(0, 0, 0, 0, 0, 0, 1, 15, 1);
    write_cfg(3'd7, c);
    access(3'd7, 1, 24'hFFFFFF, 16'h1234, c, 0, 0);
    access(3'd7, 0, 24'h00F0F0, 16'h0, c, 0, 0);
    // R9 foreign request while busy
    c = mk_cfg(2, 3, 4, 2, 2, 1, 1, 10, 1);
    write_cfg(3'd1, c);
    write_cfg(3'd2, mk_cfg(0, 0, 0, 0, 0, 0, 0, 15, 1));
    access(3'd1, 0, 24'h000321, 16'h0, c, 1, 0);
    // R10 config changed mid-access and at the accepting edge
    access(3'd1, 1, 24'h000322, 16'h5A5A, c, 2, 0);
    write_cfg(3'd1, c);
    access(3'd1, 0, 24'h000323, 16'h0, c, 3, 0);
    write_cfg(3'd1, c);
    // back-to-back: next request presented during the done cycle
    access(3'd1, 1, 24'h000010, 16'hC0DE, c, 0, 1);
    access(3'd1, 0, 24'h000012, 16'h0, c, 0, 1);
    repeat (8) @(negedge clk);

    // random accesses
    for (int i = 0; i < 60; i++) begin
      logic [2:0]  cs;
      logic [23:0] ad;
      int sz;
      cs = 3'($urandom % 8);
      sz = int'($urandom % 16);
      c = mk_cfg(int'($urandom%16), int'($urandom%16), int'($urandom%16), int'($urandom%16),
                 int'($urandom%16), 1'($urandom), 1'($urandom), sz, ($urandom % 8) != 0);
      write_cfg(cs, c);
      cfg_sel = cs;
      #1 chk("R2 random readback", cfg_rdata, c);
      ad = 24'($urandom);
      if (($urandom % 4) != 0) ad = ad & 24'((25'd1 << (9 + sz)) - 25'd1);
      access(cs, 1'($urandom), ad, 16'($urandom), c, 0, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    c2_guard();
  end
  task automatic c2_guard();
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R3 got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask
endmodule